// File: doc/BRIEF.md
# MDIO Station Management Engine

This block runs clause-22 management transactions toward an Ethernet PHY. Software loads one 32-bit maintenance word whose bit layout is the frame itself: start pattern, operation, PHY address, register number, turnaround and 16 data bits. The engine sends 32 preamble ones and then the word, most significant bit first, on the management data line, with a management clock derived from the system clock by a selectable divider.

On a read the engine releases the data line for the turnaround and data periods and shifts the PHY's 16 returned bits into the low half of the same register, so software reads the result where it wrote the command. An idle flag is the only handshake: software waits for it to be high, writes the word, and waits for it to be high again. Nothing happens unless the port enable input is high.

The sequencer has three states. `ST_IDLE` goes to `ST_PREAMBLE` on an accepted write. `ST_PREAMBLE` goes to `ST_FRAME` on the falling clock edge that ends the 32nd preamble bit. `ST_FRAME` returns to `ST_IDLE` on the falling edge that ends the 32nd frame bit. Both busy states return to `ST_IDLE` at once when the port enable drops.

Top module: `sta_mgmt_engine`

## Requirements
- R1: After reset the idle flag is 1, the management clock is 0, the data output enable is 0 and the register reads 0.
- R2: A write strobe while idle is 1 and the port enable is 1 loads the register with the written word, and idle is 0 from the next cycle for exactly 64 management clock periods.
- R3: A write strobe while the engine is busy, or while the port enable is 0, changes neither the register nor the idle flag, and starts no frame.
- R4: A frame is 32 ones followed by register bits 31 down to 0, one bit per management clock period; the word layout is bits 31:30 start (01), bit 29 read, bit 28 write, bits 27:23 PHY address, bits 22:18 register number, bits 17:16 turnaround (10), bits 15:0 data.
- R5: When bit 29 of the word is 1 the output enable is 0 for the last 18 bit periods (turnaround and data) and 1 for the 46 before; otherwise it is 1 for all 64.
- R6: On a read the data input is sampled on the rising management clock edge of each of the 16 data periods, the bits fill register bits 15:0 most significant first, and bits 31:16 keep the written value.
- R7: Each bit period starts with the management clock low for half the divisor and ends high for the other half; the data output changes only while the clock is low.
- R8: The divider select is taken when a frame starts and gives a system clocks per management clock period of 8, 16, 32, 48, 64, 96, 128, 224 for codes 0 to 7.
- R9: Dropping the port enable during a frame returns the engine to idle on the next cycle with the clock low and the output enable 0.
- R10: While idle the management clock and the output enable are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 3 | Management clock divider code |
| wr_en | input | 1 | Maintenance register write strobe |
| wr_data | input | 32 | Maintenance word to write |
| rd_data | output | 32 | Maintenance register contents |
| idle | output | 1 | High when no transaction is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The hardest situations to reach are those that collide with a frame in flight: a second write landing in the middle of a transaction and a port disable cutting a frame short. The bench schedules a write strobe a fixed number of cycles into a busy period and checks that neither the register's upper half nor the following idle period is disturbed, and it drops the port enable a fixed time into another frame to observe the abort. A responder that follows the rising clock edges supplies a known read value so the shifted-in data and the released output enable can be compared bit by bit.

// File: rtl/sta_mgmt_pkg.sv
package sta_mgmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_FRAME
    } sta_state_t;

    localparam int WORD_W    = 32;
    localparam int SEL_W     = 3;
    localparam int IDX_W     = 5;
    localparam int DATA_BITS = 16;
    localparam int READ_POS  = 29;
    localparam int TA_HI_POS = 17;

    // system clocks per management clock period for each select code
    function automatic logic [7:0] div_ratio(input logic [SEL_W-1:0] code);
        logic [7:0] r;
        case (code)
            3'd0:    r = 8'd8;
            3'd1:    r = 8'd16;
            3'd2:    r = 8'd32;
            3'd3:    r = 8'd48;
            3'd4:    r = 8'd64;
            3'd5:    r = 8'd96;
            3'd6:    r = 8'd128;
            default: r = 8'd224;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sta_mdc_div.sv
module sta_mdc_div
    import sta_mgmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             flip;

    assign flip = run && (cnt_q == half_q - CNT_W'(1));
    assign rise = flip && !mdc_q;
    assign fall = flip && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= CNT_W'(div_ratio('0) >> 1);
            cnt_q  <= '0;
            mdc_q  <= 1'b0;
        end else if (!run) begin
            half_q <= CNT_W'(div_ratio(div_sel) >> 1);
            cnt_q  <= '0;
            mdc_q  <= 1'b0;
        end else if (flip) begin
            cnt_q  <= '0;
            mdc_q  <= ~mdc_q;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sta_frame_seq.sv
module sta_frame_seq
    import sta_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              port_en,
    input  logic              rise,
    input  logic              fall,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              cap_en
);

    sta_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             is_read;
    logic             rx_window;

    assign is_read   = word[READ_POS];
    assign rx_window = is_read && (idx_q <= IDX_W'(TA_HI_POS));
    assign busy      = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PREAMBLE;
                    idx_d   = '1;
                end
            end
            ST_PREAMBLE: begin
                if (!port_en) begin
                    state_d = ST_IDLE;
                end else if (fall) begin
                    if (idx_q == '0) begin
                        state_d = ST_FRAME;
                        idx_d   = '1;
                    end else begin
                        idx_d   = idx_q - IDX_W'(1);
                    end
                end
            end
            ST_FRAME: begin
                if (!port_en) begin
                    state_d = ST_IDLE;
                end else if (fall) begin
                    if (idx_q == '0) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d   = idx_q - IDX_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        cap_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_FRAME: begin
                mdio_oe = !rx_window;
                mdio_o  = rx_window ? 1'b1 : word[idx_q];
                cap_en  = rise && is_read && (idx_q < IDX_W'(DATA_BITS));
            end
            default: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sta_mgmt_engine.sv
module sta_mgmt_engine
    import sta_mgmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              idle,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic [WORD_W-1:0] maint_q;
    logic              busy;
    logic              accept;
    logic              run;
    logic              rise;
    logic              fall;
    logic              cap_en;

    assign accept  = wr_en && port_en && !busy;
    assign run     = busy && port_en;
    assign idle    = !busy;
    assign rd_data = maint_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maint_q <= '0;
        end else if (accept) begin
            maint_q <= wr_data;
        end else if (cap_en) begin
            maint_q[DATA_BITS-1:0] <= {maint_q[DATA_BITS-2:0], mdio_i};
        end
    end

    sta_mdc_div #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_sel (div_sel),
        .mdc     (mdc),
        .rise    (rise),
        .fall    (fall)
    );

    sta_frame_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .port_en (port_en),
        .rise    (rise),
        .fall    (fall),
        .word    (maint_q),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .cap_en  (cap_en)
    );

endmodule

// File: rtl/sta_mgmt_chk.sv
module sta_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        port_en,
    input logic        wr_en,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [31:0] rd_data
);

    // R2
    accept_drops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_en && idle) |=> !idle);

    // R3
    busy_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle) |=> $stable(rd_data[31:16]));

    // R7
    mdio_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && port_en) |=> (!mdc || $stable(mdio_o)));

    // R9
    disable_forces_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en) |=> idle);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));

endmodule

bind sta_mgmt_engine sta_mgmt_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (port_en),
    .wr_en   (wr_en),
    .idle    (idle),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_data (rd_data)
);

// File: tb/sta_mgmt_engine_test.sv
`timescale 1ns/1ps
module sta_mgmt_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        idle;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int tests = 0;
    int fails = 0;
    int frames_seen = 0;
    int frames_pushed = 0;
    int r7_viol = 0;
    bit done = 0;
    logic [15:0] phy_word = '0;
    logic [63:0] exp_bits_q[$];
    logic [63:0] exp_oe_q[$];

    always #4 clk = ~clk;

    sta_mgmt_engine uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .idle(idle),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int ratio(input logic [2:0] code);
        int tbl[8] = '{8, 16, 32, 48, 64, 96, 128, 224};
        return tbl[code];
    endfunction

    function automatic logic [31:0] mk(input bit rd, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // monitor and PHY responder: collects one sample per rising MDC edge
    initial begin
        logic prev_idle = 1'b1;
        logic prev_mdc = 1'b0;
        logic prev_o = 1'b1;
        bit active = 0;
        int k = 0;
        logic [63:0] sb = '0;
        logic [63:0] so = '0;
        logic [63:0] eb, eo;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_idle && !idle) begin
                    active = 1; k = 0; mdio_i = 1'b1;
                end
                if (active && idle) active = 0;
                if (mdc && prev_mdc && (mdio_o !== prev_o)) r7_viol++;
                if (active && mdc && !prev_mdc) begin
                    sb[63-k] = mdio_o;
                    so[63-k] = mdio_oe;
                    k++;
                    mdio_i = (k >= 48 && k < 64) ? phy_word[63-k] : 1'b1;
                    if (k == 64) begin
                        active = 0;
                        frames_seen++;
                        tests++;
                        if (exp_bits_q.size() == 0) begin
                            fails++;
                            $display("FAIL R4: actual unexpected frame %h expected none", sb);
                        end else begin
                            eb = exp_bits_q.pop_front();
                            eo = exp_oe_q.pop_front();
                            if ((so !== eo) || (((sb ^ eb) & eo) != 64'd0)) begin
                                fails++;
                                $display("FAIL R4/R5: actual bits %h oe %h expected bits %h oe %h",
                                         sb, so, eb, eo);
                            end
                        end
                    end
                end
            end
            prev_idle = idle;
            prev_mdc = mdc;
            prev_o = mdio_o;
        end
    end

    task automatic run_op(input logic [31:0] word, input logic [15:0] phy, input bit intrude);
        int n;
        logic [31:0] exp_rd;
        exp_bits_q.push_back({32'hFFFF_FFFF, word});
        exp_oe_q.push_back(word[29] ? {{46{1'b1}}, 18'b0} : {64{1'b1}});
        frames_pushed++;
        phy_word = phy;
        while (!idle) @(negedge clk);
        wr_data = word;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 idle low after accept", {63'd0, idle}, 64'd0);
        check("R2 word loaded", {32'd0, rd_data}, {32'd0, word});
        n = 0;
        while (!idle) begin
            if (intrude && n == 100) begin
                wr_en = 1'b1;
                wr_data = ~word;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        wr_en = 1'b0;
        check("R2/R8 busy length", 64'(n), 64'(64 * ratio(div_sel)));
        exp_rd = word[29] ? {word[31:16], phy} : word;
        check("R6 register after frame", {32'd0, rd_data}, {32'd0, exp_rd});
        repeat (3) @(negedge clk);
        if (intrude) check("R3 no frame from busy write", {63'd0, idle}, 64'd1);
    endtask

    initial begin
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 idle", {63'd0, idle}, 64'd1);
        check("R1 mdc", {63'd0, mdc}, 64'd0);
        check("R1/R10 oe", {63'd0, mdio_oe}, 64'd0);
        check("R1 register", {32'd0, rd_data}, 64'd0);

        // R3 write with port disabled
        wr_data = 32'h1234_5678;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 disabled write idle", {63'd0, idle}, 64'd1);
        check("R3 disabled write register", {32'd0, rd_data}, 64'd0);
        port_en = 1'b1;
        @(negedge clk);

        // R4 R5 R6 with divide by 8
        run_op(mk(0, 5'd5, 5'h1F, 16'hA5C3), 16'h0000, 0);
        run_op(mk(1, 5'h1F, 5'd1, 16'h0000), 16'h796D, 0);
        run_op(mk(0, 5'd0, 5'd0, 16'hFFFF), 16'h0000, 0);
        run_op(mk(1, 5'h11, 5'h0A, 16'h0000), 16'h0001, 0);
        run_op(mk(1, 5'h0A, 5'h15, 16'h0000), 16'h8000, 0);

        // R3 write while busy
        run_op(mk(0, 5'h03, 5'h04, 16'h0F0F), 16'h0000, 1);

        // R9 abort by port disable
        wr_data = mk(0, 5'd7, 5'd9, 16'h5555);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        keep = rd_data;
        repeat (150) @(negedge clk);
        port_en = 1'b0;
        @(negedge clk);
        check("R9 abort idle", {63'd0, idle}, 64'd1);
        check("R9/R10 abort mdc low", {63'd0, mdc}, 64'd0);
        check("R9/R10 abort oe low", {63'd0, mdio_oe}, 64'd0);
        check("R9 register kept", {32'd0, rd_data}, {32'd0, keep});
        port_en = 1'b1;
        repeat (2) @(negedge clk);

        // R8 other divider codes
        div_sel = 3'd3;
        run_op(mk(0, 5'd2, 5'd3, 16'hC001), 16'h0000, 0);
        div_sel = 3'd4;
        run_op(mk(1, 5'd9, 5'd2, 16'h0000), 16'h3CA7, 0);

        repeat (5) @(negedge clk);
        check("R4 all frames seen", 64'(frames_seen), 64'(frames_pushed));
        check("R7 mdio stable while mdc high", 64'(r7_viol), 64'd0);
        finish_run();
    end

    initial begin
        #(8 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule